// File: doc/BRIEF.md
# Byte-Masked Double-Rate Write Capture

This block is the receive side of the write path in a 16-bit double-data-rate memory. Each byte lane has its own strobe and its own mask input. A lane latches one data beat and its mask bit on the rising strobe edge, and a second beat and mask bit on the falling edge. The core clock then takes each pair of beats and commits the unmasked bytes to a small internal word array. The two beats go to two consecutive burst addresses.

The command side starts a burst with a one-cycle pulse. The pulse carries the starting column and a two-bit burst-length code. Beat addresses start at that column and wrap inside an aligned window the size of the burst. The array has a combinational read port, which is how the surrounding logic or a bench sees what the burst left behind. Read launch, preamble checks and strobe alignment are handled elsewhere.

Top module: `ddr_wcap`

## Requirements
- R1: While reset is asserted, and after it is released until the first burst, every array word reads as zero.
- R2: In each burst pair, the beat captured on the rising strobe edge is written to burst beat 2k. The beat captured on the falling edge is written to beat 2k+1.
- R3: `lane_stb[0]` and `lane_mask[0]` govern data bits 7:0. `lane_stb[1]` and `lane_mask[1]` govern bits 15:8. Each lane is qualified independently.
- R4: A byte whose lane mask is high with its beat keeps its previous contents. An unmasked byte takes the new data.
- R5: `burst_len` code 2'b01 selects 2 beats, 2'b10 selects 4 and 2'b11 selects 8. No word outside the burst's addresses changes.
- R6: Beat i of a burst of length L starting at column C is written to address (C with its low log2(L) bits cleared) OR ((C+i) mod L).
- R7: With the start pulse sampled at core edge E, the strobes of pair k fall inside core cycle E+k+1. That pair is written at edge E+k+2 and is not visible before that edge.
- R8: A start pulse sampled while a burst is still in progress is ignored.
- R9: A start pulse with `burst_len` 2'b00 is ignored, and no word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_stb | input | 2 | Per-lane write strobe; bit 0 is the lower byte lane |
| wdata | input | 16 | Write data, captured on both edges of its lane strobe |
| lane_mask | input | 2 | Per-lane byte mask, high blocks the byte of that beat |
| burst_go | input | 1 | One-cycle burst start pulse |
| burst_col | input | 4 | Starting column of the burst |
| burst_len | input | 2 | Burst length code: 01=2, 10=4, 11=8, 00 reserved |
| rd_addr | input | 4 | Read address of the array |
| rd_data | output | 16 | Array word at `rd_addr`, combinational |

## Verification
The assertions rely on two conditions. The two write addresses of a pair must differ, which any legal length code guarantees. Each strobe pair must finish inside its core cycle, so the capture registers are stable at the next core edge. The stimulus keeps to this by raising the strobes a quarter period after a core edge and dropping them three quarters in. The upper lane runs half a nanosecond behind the lower. Data and mask change only between strobe edges. No burst starts before the previous burst's last pair has been written, except in the one case that tests a start pulse arriving mid-burst.

// File: rtl/wcap_pkg.sv
`timescale 1ns/1ps
package wcap_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_XFER = 2'd2
  } wcap_st_e;

  // index of the final beat pair for a length code (0 for the reserved code)
  function automatic logic [1:0] last_pair(input logic [1:0] code);
    case (code)
      2'b01:   last_pair = 2'd0;
      2'b10:   last_pair = 2'd1;
      2'b11:   last_pair = 2'd3;
      default: last_pair = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/wcap_lane.sv
`timescale 1ns/1ps
module wcap_lane #(
  parameter int W = 8
) (
  input  logic         stb,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         m,
  output logic [W-1:0] rise_d,
  output logic         rise_m,
  output logic [W-1:0] fall_d,
  output logic         fall_m
);
  // even beat: rising strobe edge
  always_ff @(posedge stb or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= '0;
      rise_m <= 1'b1;
    end else begin
      rise_d <= d;
      rise_m <= m;
    end
  end

  // odd beat: falling strobe edge
  always_ff @(negedge stb or negedge rst_n) begin
    if (!rst_n) begin
      fall_d <= '0;
      fall_m <= 1'b1;
    end else begin
      fall_d <= d;
      fall_m <= m;
    end
  end
endmodule

// File: rtl/wcap_seq.sv
`timescale 1ns/1ps
module wcap_seq
  import wcap_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] col,
  input  logic [1:0]    len,
  output logic          we,
  output logic [AW-1:0] wa0,
  output logic [AW-1:0] wa1
);
  wcap_st_e      st_q, st_d;
  logic [AW-1:0] col_q, col_d;
  logic [AW-1:0] msk_q, msk_d;
  logic [1:0]    idx_q, idx_d;
  logic [1:0]    last_q, last_d;
  logic          accept;
  logic [AW-1:0] off0, off1;

  assign accept = (st_q == ST_IDLE) && go && (len != 2'b00);

  always_comb begin
    st_d   = st_q;
    col_d  = col_q;
    msk_d  = msk_q;
    idx_d  = idx_q;
    last_d = last_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ST_GAP;
        col_d  = col;
        last_d = last_pair(len);
        msk_d  = AW'({last_pair(len), 1'b1});
      end
      ST_GAP: begin
        st_d  = ST_XFER;
        idx_d = '0;
      end
      ST_XFER: begin
        if (idx_q == last_q) st_d = ST_IDLE;
        else                 idx_d = idx_q + 2'd1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      msk_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (accept) begin
        col_q  <= col_d;
        msk_q  <= msk_d;
        last_q <= last_d;
      end
    end
  end

  assign we   = (st_q == ST_XFER);
  assign off0 = col_q + AW'({idx_q, 1'b0});
  assign off1 = off0 + AW'(1);
  assign wa0  = (col_q & ~msk_q) | (off0 & msk_q);
  assign wa1  = (col_q & ~msk_q) | (off1 & msk_q);

  // R7: one empty cycle follows an accepted start, then the first pair writes
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !we);
  a_r7_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 we);
  // R9: reserved length code starts nothing
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && st_q == ST_IDLE && go && len == 2'b00) |=> ##1 !we);
  // R6: both write addresses stay inside the aligned burst window
  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (((wa0 ^ col_q) & ~msk_q) == '0) && (((wa1 ^ col_q) & ~msk_q) == '0));
  // R5: the burst ends after its last pair
  a_r5_end: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx_q == last_q) |=> !we);
  // R8: a start seen mid-burst does not change the burst window
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && go) |=> $stable(col_q) && $stable(msk_q));
endmodule

// File: rtl/wcap_array.sv
`timescale 1ns/1ps
module wcap_array
  import wcap_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         wa0,
  input  logic [AW-1:0]         wa1,
  input  logic [LANES*BYTE_W-1:0] d0,
  input  logic [LANES*BYTE_W-1:0] d1,
  input  logic [LANES-1:0]      k0,
  input  logic [LANES-1:0]      k1,
  input  logic [AW-1:0]         ra,
  output logic [LANES*BYTE_W-1:0] rdat
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * BYTE_W;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  always_comb begin
    mem_d = mem_q;
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (k0[l]) mem_d[wa0][l*BYTE_W +: BYTE_W] = d0[l*BYTE_W +: BYTE_W];
        if (k1[l]) mem_d[wa1][l*BYTE_W +: BYTE_W] = d1[l*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  assign rdat = mem_q[ra];

  // R6: the two beats of a pair never share an address
  a_r6_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wa0 != wa1);
  // R4: with no write the read word holds for a held address
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (ra != $past(ra)) || (rdat == $past(rdat)));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4: a masked byte of either beat keeps its stored value
    a_r4_masked_even: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !k0[g]) |-> mem_d[wa0][g*BYTE_W +: BYTE_W] == mem_q[wa0][g*BYTE_W +: BYTE_W]);
    a_r4_masked_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !k1[g]) |-> mem_d[wa1][g*BYTE_W +: BYTE_W] == mem_q[wa1][g*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/ddr_wcap.sv
`timescale 1ns/1ps
module ddr_wcap
  import wcap_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_stb,
  input  logic [LANES*BYTE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    burst_go,
  input  logic [AW-1:0]           burst_col,
  input  logic [1:0]              burst_len,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*BYTE_W-1:0] rd_data
);
  localparam int DW = LANES * BYTE_W;

  logic [1:0]       rs_q;
  logic             core_rst_n;
  logic [DW-1:0]    rise_d, fall_d;
  logic [LANES-1:0] rise_m, fall_m;
  logic             we;
  logic [AW-1:0]    wa0, wa1;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wcap_lane #(.W(BYTE_W)) u_lane (
      .stb    (lane_stb[g]),
      .rst_n  (rst_n),
      .d      (wdata[g*BYTE_W +: BYTE_W]),
      .m      (lane_mask[g]),
      .rise_d (rise_d[g*BYTE_W +: BYTE_W]),
      .rise_m (rise_m[g]),
      .fall_d (fall_d[g*BYTE_W +: BYTE_W]),
      .fall_m (fall_m[g])
    );
  end

  wcap_seq #(.AW(AW)) u_seq (
    .clk   (clk),
    .rst_n (core_rst_n),
    .go    (burst_go),
    .col   (burst_col),
    .len   (burst_len),
    .we    (we),
    .wa0   (wa0),
    .wa1   (wa1)
  );

  wcap_array #(.AW(AW), .LANES(LANES)) u_arr (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (we),
    .wa0   (wa0),
    .wa1   (wa1),
    .d0    (rise_d),
    .d1    (fall_d),
    .k0    (~rise_m),
    .k1    (~fall_m),
    .ra    (rd_addr),
    .rdat  (rd_data)
  );
endmodule

// File: tb/sim_ddr_wcap.sv
`timescale 1ns/100ps
module sim_ddr_wcap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lane_stb = 2'b00;
  logic [15:0] wdata = '0;
  logic [1:0]  lane_mask = 2'b00;
  logic        burst_go = 1'b0;
  logic [3:0]  burst_col = '0;
  logic [1:0]  burst_len = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [15:0] expm [16];

  always #5 clk = ~clk;

  ddr_wcap u0 (
    .clk(clk), .rst_n(rst_n), .lane_stb(lane_stb), .wdata(wdata),
    .lane_mask(lane_mask), .burst_go(burst_go), .burst_col(burst_col),
    .burst_len(burst_len), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {col[37:34], len[33:32], seed[31:16], lower masks[15:8], upper masks[7:0]}
  localparam logic [37:0] VEC [6] = '{
    {4'd0,  2'd3, 16'hA000, 8'h00, 8'h00},
    {4'd13, 2'd2, 16'h3C10, 8'h02, 8'h04},
    {4'd3,  2'd1, 16'h7711, 8'h01, 8'h02},
    {4'd6,  2'd3, 16'h0F0F, 8'hF0, 8'h0F},
    {4'd10, 2'd2, 16'hBEEF, 8'hFF, 8'hFF},
    {4'd1,  2'd3, 16'h5A5A, 8'h55, 8'hAA}
  };

  function automatic logic [15:0] beat(input logic [15:0] seed, input int i);
    return seed + 16'(i) * 16'h1357;
  endfunction

  function automatic logic [3:0] baddr(input logic [3:0] col, input int bl, input int i);
    logic [3:0] m;
    m = 4'(bl - 1);
    return (col & ~m) | (4'(int'(col) + i) & m);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #1;
      check(req, rd_data, expm[a]);
    end
  endtask

  task automatic burst(input logic [3:0] col, input logic [1:0] len, input logic [15:0] seed,
                       input logic [7:0] mlo, input logic [7:0] mhi,
                       input bit extra_go, input bit probe);
    int bl;
    int pairs;
    bl    = (len == 2'b00) ? 2 : (1 << len);
    pairs = bl / 2;
    rd_addr = baddr(col, bl, 0);
    @(posedge clk); #1;
    burst_go = 1'b1; burst_col = col; burst_len = len;
    @(posedge clk); #1;                 // start sampled at this edge (E0)
    if (extra_go) begin
      burst_col = 4'd8; burst_len = 2'd3;
    end else begin
      burst_go = 1'b0;
    end
    for (int k = 0; k < pairs; k++) begin
      @(posedge clk); #1;
      if (k == 1) burst_go = 1'b0;
      wdata = beat(seed, 2*k); lane_mask = {mhi[2*k], mlo[2*k]};
      #1.5 lane_stb[0] = 1'b1;
      #0.5 lane_stb[1] = 1'b1;
      #1.5 wdata = beat(seed, 2*k+1); lane_mask = {mhi[2*k+1], mlo[2*k+1]};
      #3   lane_stb[0] = 1'b0;
      #0.5 lane_stb[1] = 1'b0;
      #0.5;
      if (probe && k == 0) check("R7 not yet written", rd_data, expm[rd_addr]);
    end
    burst_go = 1'b0;
    @(posedge clk); #2;
    if (len != 2'b00) begin
      for (int i = 0; i < bl; i++) begin
        logic [3:0] a;
        a = baddr(col, bl, i);
        if (!mlo[i]) expm[a][7:0]  = beat(seed, i)[7:0];
        if (!mhi[i]) expm[a][15:8] = beat(seed, i)[15:8];
      end
    end
    if (probe) begin
      rd_addr = baddr(col, bl, 0);
      #0.5 check("R7 written after pair edge", rd_data, expm[rd_addr]);
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16; a++) expm[a] = '0;
    #3;
    check_all("R1 during reset");
    #20 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check_all("R1 after release");

    // vector walk: order, lanes, masks, lengths, wrap (R2 R3 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      burst(VEC[v][37:34], VEC[v][33:32], VEC[v][31:16], VEC[v][15:8], VEC[v][7:0], 1'b0, 1'b0);
      check_all("R2 R3 R4 R5 R6 vector");
    end

    // R7: pair visible only after its commit edge
    burst(4'd14, 2'd1, 16'hC3A5, 8'h00, 8'h00, 1'b0, 1'b1);
    check_all("R7 timing burst");

    // R8: start pulse held through the gap and first pair is ignored
    burst(4'd4, 2'd2, 16'h9001, 8'h00, 8'h00, 1'b1, 1'b0);
    repeat (6) @(posedge clk);
    #2;
    check_all("R8 start while busy");

    // R9: reserved length code writes nothing even with strobes toggling
    burst(4'd2, 2'd0, 16'hDEAD, 8'h00, 8'h00, 1'b0, 1'b0);
    repeat (4) @(posedge clk);
    #2;
    check_all("R9 reserved length");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule